// File: doc/BRIEF.md
# Bit-to-Byte Frame De-Transposer

This block takes a serial time-division frame in which the bits of the users are interleaved, every user's bit 0 first, then every user's bit 1 and so on. It rebuilds the frame so that each time slot carries one whole user byte. A frame has 32 slots of 8 bits, which is 256 bits. Only the first 16 slots belong to active users. The rebuilt slots 16 to 31 carry zeros.

The block runs from a clock at twice the bit rate. A half-bit counter is brought back to the frame start whenever the active-low frame sync is sampled low. Input bits are captured on every second clock edge into a storage buffer. When the last bit of a frame has been captured, the whole storage buffer is copied into a shipping buffer in the same edge. Until the next copy, the shipping buffer feeds the serial output in byte order. The first output bit of the new frame leaves in that same edge, so it is taken straight from the storage buffer. Frames follow each other with no gap. A valid flag rises when the first complete frame has been captured.

Top module: `frame_detranspose`

## Requirements
- R1: While rst_n is low and on the first edge after its release, sdo and frame_valid are 0.
- R2: An internal half-bit count h advances by one on every rising clk edge and wraps from 511 to 0 on its own. On an edge where h is odd, input bit position h/2 of the frame is captured from sdi. The edge with h = 511 completes a frame.
- R3: When fsync_n is sampled low on an edge, h is 0 after that edge. The bit capture due on that edge still takes place. A sync pulse in the middle of a frame therefore realigns the block to the next frame start.
- R4: In the incoming frame, bit b of user s is at position b*32+s, so the bit-major order is used. In the outgoing frame, that bit is at position s*8+b. Each byte is sent least significant bit first, and slot 0 goes out first.
- R5: Output positions 64*2 to 255, which are slots 16 to 31, always carry 0 on sdo.
- R6: Output position p of a frame is presented on sdo right after the edge that captures input position p-1 of the following frame. Position 0 appears right after the edge that completes the frame, so the latency is one bit period.
- R7: sdo changes only right after an edge with h odd. It holds its value for two clk cycles.
- R8: frame_valid goes to 1 right after the first frame-completing edge following reset and then stays at 1. A frame cut short by a sync pulse is never shipped, and sdo stays 0 while frame_valid is 0.
- R9: Consecutive frames are shipped back to back. The last output bit of one frame is followed directly by the first output bit of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n | input | 1 | Active-low frame sync, returns the half-bit count to 0 |
| sdi | input | 1 | Serial input in bit-major order |
| sdo | output | 1 | Serial output in byte-major order |
| frame_valid | output | 1 | High once a complete frame has been captured |

## Verification
A bit driven for the two clocks around the edge with h = 2k+1 is captured on that edge. Its rebuilt copy leaves on sdo after the edge with h = 2p-1 of the next frame, where p is its output position. Position 0 follows directly on the edge h = 511 that completes the frame, and frame_valid rises on that same edge. The bench model advances on every rising edge and is compared with sdo and frame_valid on every falling edge. The named spot checks sample 1 ns after the frame-completing edge, which is where the first rebuilt bit and the valid flag are due.

// File: rtl/frame_detranspose.sv
module frame_detranspose #(
  parameter int SLOTS  = 32,
  parameter int BITS   = 8,
  parameter int ACTIVE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_n,
  input  logic sdi,
  output logic sdo,
  output logic frame_valid
);
  localparam int FRAME  = SLOTS * BITS;
  localparam int HALVES = 2 * FRAME;
  localparam int HW     = $clog2(HALVES);
  localparam int IW     = $clog2(FRAME);

  logic [HW-1:0]    hcnt;
  logic [FRAME-1:0] store;
  logic [FRAME-1:0] ship;
  logic [IW-1:0]    nxt;
  logic [IW-1:0]    src;
  logic             pick;
  int               nslot;
  int               nbit;

  wire          strobe = hcnt[0];
  wire [IW-1:0] idx    = hcnt[HW-1:1];
  wire          done   = strobe && (idx == IW'(FRAME - 1));

  always_comb begin
    nxt   = done ? '0 : idx + IW'(1);
    nslot = int'(nxt) / BITS;
    nbit  = int'(nxt) % BITS;
    src   = IW'(nbit * SLOTS + nslot);
    pick  = 1'b0;
    if (nslot < ACTIVE)
      pick = done ? store[src] : ship[src];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt        <= '0;
      store       <= '0;
      ship        <= '0;
      sdo         <= 1'b0;
      frame_valid <= 1'b0;
    end else begin
      hcnt <= (!fsync_n || hcnt == HW'(HALVES - 1)) ? '0 : hcnt + HW'(1);
      if (strobe) begin
        store[idx] <= sdi;
        sdo        <= pick;
      end
      if (done) begin
        ship        <= {sdi, store[FRAME-2:0]};
        frame_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_detranspose_chk.sv
module frame_detranspose_chk #(
  parameter int SLOTS  = 32,
  parameter int BITS   = 8,
  parameter int ACTIVE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic fsync_n,
  input logic sdo,
  input logic frame_valid
);
  localparam int FRAME  = SLOTS * BITS;
  localparam int HALVES = 2 * FRAME;
  localparam int HW     = $clog2(HALVES);

  logic [HW-1:0] ck_h;
  int            ck_slot;
  wire           ck_odd  = ck_h[0];
  wire           ck_last = ck_odd && (int'(ck_h) / 2 == FRAME - 1);

  always_comb ck_slot = ((int'(ck_h) / 2 + 1) % FRAME) / BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_h <= '0;
    else if (!fsync_n || int'(ck_h) == HALVES - 1) ck_h <= '0;
    else ck_h <= ck_h + HW'(1);
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sdo && !frame_valid));

  // R7
  hold_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_odd |=> $stable(sdo));

  // R5
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_odd && ck_slot >= ACTIVE) |=> !sdo);

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> frame_valid);

  // R8
  no_early_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> !sdo);

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> $past(ck_last));
endmodule

bind frame_detranspose frame_detranspose_chk #(
  .SLOTS(SLOTS), .BITS(BITS), .ACTIVE(ACTIVE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n),
  .sdo(sdo), .frame_valid(frame_valid)
);

// File: tb/frame_detranspose_test.sv
`timescale 1ns/1ps
module frame_detranspose_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, frame_valid;

  int checks = 0;
  int errors = 0;

  logic [7:0] ub [32];

  bit inb [256];
  bit cur [256];
  int mh = 0;
  bit mv = 1'b0;
  bit exp_sdo = 1'b0;
  bit prev_exp = 1'b0;
  logic prev_sdo = 1'b0;
  int exp_slot = 0;

  frame_detranspose uut (
    .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .sdi(sdi),
    .sdo(sdo), .frame_valid(frame_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: capture, then transpose a whole frame at completion
  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 1'b0; exp_sdo = 1'b0; exp_slot = 0;
      for (int i = 0; i < 256; i++) cur[i] = 1'b0;
    end else begin
      if (mh % 2 == 1) begin
        int k, p;
        k = mh / 2;
        inb[k] = sdi;
        if (k == 255) begin
          for (int s = 0; s < 32; s++)
            for (int b = 0; b < 8; b++)
              cur[s*8+b] = (s < 16) ? inb[b*32+s] : 1'b0;
          mv = 1'b1;
          p = 0;
        end else p = k + 1;
        exp_sdo = cur[p];
        exp_slot = p / 8;
      end
      mh = (!fsync_n || mh == 511) ? 0 : mh + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      tag = (exp_slot >= 16) ? "R5" : "R4";
      if (prev_exp == exp_sdo && sdo !== prev_sdo) tag = "R7";
      chk(sdo === exp_sdo, tag, sdo, exp_sdo);
      chk(frame_valid === mv, "R8", frame_valid, mv);
    end
    prev_exp = exp_sdo;
    prev_sdo = sdo;
  end

  task automatic tick(input logic fs, input logic d);
    @(negedge clk);
    fsync_n = fs;
    sdi = d;
  endtask

  task automatic send_frame(input bit realign);
    for (int k = 0; k < 256; k++) begin
      logic bv;
      bv = ub[k % 32][k / 32];
      tick(1'b1, bv);
      tick((realign && k == 255) ? 1'b0 : 1'b1, bv);
    end
  endtask

  task automatic after_swap(input string tag);
    @(posedge clk);
    #1;
    chk(sdo === ub[0][0], tag, sdo, ub[0][0]);
    chk(frame_valid === 1'b1, tag, frame_valid, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(sdo === 1'b0, "R1", sdo, 1'b0);
    chk(frame_valid === 1'b0, "R1", frame_valid, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(sdo === 1'b0, "R1", sdo, 1'b0);
    chk(frame_valid === 1'b0, "R1", frame_valid, 1'b0);

    // R3: misaligned partial frame, then a sync pulse mid-frame
    tick(1'b0, 1'b0);
    for (int k = 0; k < 100; k++) begin
      logic r;
      r = 1'($urandom);
      tick(1'b1, r);
      tick(1'b1, r);
    end
    tick(1'b0, 1'b1);
    @(posedge clk);
    #1;
    chk(frame_valid === 1'b0, "R8", frame_valid, 1'b0);

    for (int s = 0; s < 32; s++) ub[s] = 8'(s * 37 + 5);
    ub[0] = 8'h01;
    send_frame(1'b1);
    after_swap("R6");
    chk(sdo === 1'b1, "R3", sdo, 1'b1);

    for (int s = 0; s < 32; s++) ub[s] = 8'hFF;
    send_frame(1'b1);
    after_swap("R9");

    for (int s = 0; s < 32; s++) ub[s] = 8'($urandom);
    ub[0] = 8'h33;
    send_frame(1'b0);
    after_swap("R2");

    for (int s = 0; s < 32; s++) ub[s] = (s % 2 == 0) ? 8'hAA : 8'h55;
    ub[0] = 8'hA5;
    send_frame(1'b1);
    after_swap("R9");

    for (int s = 0; s < 32; s++) ub[s] = 8'h00;
    send_frame(1'b1);
    after_swap("R4");
    repeat (8) tick(1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule